// File: doc/BRIEF.md
# Burst-of-Four Lane-Masked Write Memory

This block is a synchronous on-chip memory whose write side works in bursts. A single write command carries a base address. The four clocks that follow it each deliver one data word to consecutive word locations. Every delivered word comes with a mask that has one bit per lane. A high mask bit protects its lane, so the old contents of that lane at that location stay in place. A low mask bit lets the new data through for that lane.

The lane width and the lane count are parameters. The default has two 9-bit lanes, so one burst moves 72 bits. A narrow build uses two 4-bit lanes, so each lane is a nybble.

While a burst is running, the memory raises `busy`, and any further write command is dropped. A separate read port returns the whole stored word, with every lane, one clock after the read address is presented. The array clears to zero on reset, so a lane that has never been written reads as zero.

Top module: `burst4_wmem`

## Requirements
- R1: After reset, every word reads as zero and `busy` is low.
- R2: A write command is accepted when `wr_cmd` is high on a clock edge at which `busy` is low. `busy` is then high for exactly the four following clock cycles. A command on the first edge after `busy` falls is accepted.
- R3: Beat n (n = 0..3) of a burst writes word address {base, n}, where n forms the two low address bits. Its data is sampled on the (n+1)-th clock edge after the accepting edge.
- R4: Mask bit k is sampled on the same edge as the data of its beat. When it is 1, data bits k*LANE_W up to k*LANE_W+LANE_W-1 of the addressed word keep their old value. When it is 0, those bits take `wr_data`.
- R5: The mask of each beat is independent of the masks of the other beats. For example, with the mask sequence (lane0,lane1) = (0,1), (1,0), (0,0), (1,0), lane 0 is written on beats 0 and 2, and lane 1 is written on beats 1, 2 and 3.
- R6: A write command that arrives while `busy` is high is ignored. The running burst continues unchanged, and the base address carried by the ignored command is not written.
- R7: `rd_data` presents the full stored word at `rd_addr`, including masked lanes, one clock after `rd_addr` is presented, and holds that value until the next edge.
- R8: With LANE_W = 4, the masks act on 4-bit nybbles under the same rule as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command strobe |
| wr_base | input | ADDR_W-2 | Base address of the burst |
| wr_data | input | LANE_W*LANES | Data word of the current beat |
| wr_mask | input | LANES | Per-lane inhibit for the current beat, 1 = keep |
| busy | output | 1 | A burst is in progress |
| rd_addr | input | ADDR_W | Word read address |
| rd_data | output | LANE_W*LANES | Stored word, registered |

## Verification
A wrong beat counter or a stale base register puts a word at the wrong address. It is seen on the next readback of the four burst words, or of the neighbouring words that must stay unwritten. A lane select or mask sense that is off changes a lane that should have been kept, or keeps one that should have changed. It shows on the read port one clock after that word is addressed. A control state that restarts on an ignored command, or that ends early or late, shows at once on `busy` within the burst window. It also shows as writes at the injected base address.

// File: rtl/burst4_wmem.sv
module burst4_wmem #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_cmd,
  input  logic [ADDR_W-3:0]         wr_base,
  input  logic [LANE_W*LANES-1:0]   wr_data,
  input  logic [LANES-1:0]          wr_mask,
  output logic                      busy,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANE_W*LANES-1:0]   rd_data
);
  localparam int W     = LANE_W * LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0]        mem [DEPTH];
  logic                active;
  logic [1:0]          beat;
  logic [ADDR_W-3:0]   base_q;
  logic [W-1:0]        merged;

  wire                 accept   = wr_cmd & ~active;
  wire [ADDR_W-1:0]    waddr    = {base_q, beat};
  wire [W-1:0]         cur_word = mem[waddr];

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = wr_mask[l] ? cur_word[l*LANE_W +: LANE_W]
                                                     : wr_data[l*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= 2'd0;
      base_q <= '0;
    end else if (accept) begin
      active <= 1'b1;
      beat   <= 2'd0;
      base_q <= wr_base;
    end else if (active) begin
      beat <= beat + 2'd1;
      if (beat == 2'd3) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (active) begin
      mem[waddr] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

  assign busy = active;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy) |=> busy); // R2
  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2) && $past(busy, 3)) |=> !busy); // R2
  AST_BUSY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy, 4)); // R2
  AST_IGNORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd && beat != 2'd3) |=> (beat == $past(beat) + 2'd1 && base_q == $past(base_q))); // R6
  AST_FULL_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (&wr_mask)) |=> mem[$past(waddr)] == $past(cur_word)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 1'b1 |-> rd_data == $past(mem[rd_addr])); // R7
endmodule

// File: tb/burst4_wmem_bench.sv
`timescale 1ns/1ps
module burst4_wmem_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_cmd = 0;
  logic [3:0]  wr_base = 0;
  logic [17:0] wr_data = 0;
  logic [1:0]  wr_mask = 0;
  logic        busy;
  logic [5:0]  rd_addr = 0;
  logic [17:0] rd_data;

  logic       n_cmd = 0;
  logic [1:0] n_base = 0;
  logic [7:0] n_data = 0;
  logic [1:0] n_mask = 0;
  logic       n_busy;
  logic [3:0] n_raddr = 0;
  logic [7:0] n_rdata;

  burst4_wmem #(.LANE_W(9), .LANES(2), .ADDR_W(6)) u_burst4_wmem (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_base(wr_base), .wr_data(wr_data),
    .wr_mask(wr_mask), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

  burst4_wmem #(.LANE_W(4), .LANES(2), .ADDR_W(4)) u_narrow (
    .clk(clk), .rst_n(rst_n), .wr_cmd(n_cmd), .wr_base(n_base), .wr_data(n_data),
    .wr_mask(n_mask), .busy(n_busy), .rd_addr(n_raddr), .rd_data(n_rdata));

  int checks = 0;
  int errors = 0;
  logic [17:0] exp_w [64];
  logic [7:0]  exp_n [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] merge_w(input logic [17:0] old, input logic [17:0] d, input logic [1:0] m);
    merge_w = old;
    if (!m[0]) merge_w[8:0]  = d[8:0];
    if (!m[1]) merge_w[17:9] = d[17:9];
  endfunction

  task automatic read_w(input logic [5:0] a, input string req);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #2;
    check(req, rd_data, exp_w[a]);
  endtask

  task automatic burst_w(input logic [3:0] base, input logic [71:0] d, input logic [7:0] m,
                         input int inj_beat, input logic [3:0] inj_base);
    @(negedge clk);
    check("R2 idle before command", busy, 0);
    wr_cmd = 1; wr_base = base;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check("R2 busy during burst", busy, 1);
      wr_cmd = (n == inj_beat); wr_base = (n == inj_beat) ? inj_base : base;
      wr_data = d[n*18 +: 18]; wr_mask = m[n*2 +: 2];
      exp_w[{base, n[1:0]}] = merge_w(exp_w[{base, n[1:0]}], wr_data, wr_mask);
    end
    @(negedge clk);
    check("R2 busy falls after four beats", busy, 0);
    wr_cmd = 0; wr_data = 0; wr_mask = 0;
    for (int n = 0; n < 4; n++) read_w({base, n[1:0]}, "R3 R4 burst word");
  endtask

  task automatic test_reset;
    check("R1 busy after reset", busy, 0);
    read_w(6'd0, "R1 word 0 zero");
    read_w(6'd13, "R1 word 13 zero");
    read_w(6'd63, "R1 word 63 zero");
  endtask

  task automatic test_example_masks;
    burst_w(4'd3, {18'h2AAAA, 18'h15555, 18'h3FFFF, 18'h12345}, {2'b01, 2'b00, 2'b01, 2'b10}, 9, 0);
    read_w(6'd12, "R5 beat0 lane0 written lane1 kept");
    check("R5 beat0 value", exp_w[12], {9'h000, 9'h145});
    read_w(6'd15, "R5 beat3 lane0 kept");
    check("R5 beat3 value", exp_w[15], {9'h155, 9'h000});
  endtask

  task automatic test_full_write;
    burst_w(4'd0, {18'h00011, 18'h3FE01, 18'h1FF00, 18'h2C0DE}, 8'h00, 9, 0);
  endtask

  task automatic test_all_masked;
    burst_w(4'd3, {18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF}, 8'hFF, 9, 0);
    read_w(6'd13, "R4 fully masked word unchanged");
  endtask

  task automatic test_ignore;
    burst_w(4'd10, {18'h0ABCD, 18'h10101, 18'h20202, 18'h30303}, 8'h00, 1, 4'd11);
    for (int n = 0; n < 4; n++) read_w({4'd11, n[1:0]}, "R6 ignored base unwritten");
  endtask

  task automatic test_back_to_back;
    burst_w(4'd5, {18'h11111, 18'h22222, 18'h33333, 18'h04444}, 8'h00, 9, 0);
    burst_w(4'd6, {18'h05555, 18'h06666, 18'h07777, 18'h08888}, 8'h00, 9, 0);
    read_w(6'd20, "R3 first back-to-back word intact");
  endtask

  task automatic test_read_latency;
    @(negedge clk); rd_addr = 6'd40;
    @(posedge clk); #2;
    check("R7 word after one clock", rd_data, exp_w[40]);
    @(negedge clk); rd_addr = 6'd0;
    #2;
    check("R7 holds until next edge", rd_data, exp_w[40]);
    @(posedge clk); #2;
    check("R7 new address next clock", rd_data, exp_w[0]);
  endtask

  task automatic test_narrow;
    logic [7:0]  d [4];
    logic [1:0]  m [4];
    d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'hF0; d[3] = 8'h69;
    m[0] = 2'b10; m[1] = 2'b01; m[2] = 2'b00; m[3] = 2'b11;
    @(negedge clk); n_cmd = 1; n_base = 2'd2;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      n_cmd = 0; n_data = d[n]; n_mask = m[n];
      exp_n[{2'd2, n[1:0]}] = {m[n][1] ? 4'h0 : d[n][7:4], m[n][0] ? 4'h0 : d[n][3:0]};
    end
    @(negedge clk); n_data = 0; n_mask = 0;
    check("R8 narrow busy falls", n_busy, 0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); n_raddr = {2'd2, n[1:0]};
      @(posedge clk); #2;
      check("R8 narrow nybble mask", n_rdata, exp_n[{2'd2, n[1:0]}]);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_w[i] = '0;
    for (int i = 0; i < 16; i++) exp_n[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    test_reset;
    test_example_masks;
    test_full_write;
    test_all_masked;
    test_ignore;
    test_back_to_back;
    test_read_latency;
    test_narrow;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule